// File: doc/BRIEF.md
# Fault Monitor with Retry Control

This block watches four digitized power-stage quantities: input voltage, output voltage, output current and hot-spot temperature. Each sample set arrives with a one-cycle valid strobe. The block compares every sample set against programmable warning and fault thresholds and keeps a 16-bit status word whose bits stay set until a clear-faults pulse. From that state it derives a shutdown request, an alert request and a hysteretic power-good flag. Converting samples from the bus number format, the converter itself and the management bus are handled elsewhere. All values are plain unsigned integers in matching units.

Three protected channels have their own response byte: output overvoltage, output overcurrent and overtemperature. The upper two bits of a response byte choose whether a fault shuts the output down. The middle three bits choose between endless hiccup restart and latch-off. The lowest three bits are the delay field, and only zero is accepted there. During a hiccup the block holds the shutdown for a programmable number of cycles. It then releases the shutdown only if the latest sample shows that the condition has cleared. The input undervoltage lockout and the input overvoltage fault act on their own and release by themselves.

Top module: `fault_monitor`

## Requirements
- R1: The undervoltage lockout starts engaged. It releases on a valid sample with `vin >= vin_on_lim` and engages again on a valid sample with `vin < vin_off_lim`. Between those limits it keeps its state. While engaged, `shdn_req` is 1 and status bits 3 and 13 are set.
- R2: `pg` starts at 0. It rises on a valid sample with `vout >= pg_on_lim` and falls on a valid sample with `vout <= pg_off_lim`. Between those limits it holds.
- R3: A valid sample at or above a limit sets status bits as follows. The overvoltage fault sets bits 15 and 5, and the overvoltage warning sets bit 15. The overcurrent fault sets bits 14 and 4, and the overcurrent warning sets bit 14. The temperature fault or warning sets bit 2. Bit 11 reports that `pg` is 0.
- R4: Status bits stay set after their condition goes away. A `clear_faults` pulse reloads the word with only the conditions still present.
- R5: `alert_req` rises when any status bit goes from 0 to 1. It falls only on `clear_faults`, and bits that persist through a clear do not raise it again.
- R6: A response byte with action bits [7:6] = 00 records the fault in the status word but never requests shutdown.
- R7: A nonzero action with retry bits [5:3] = 111 requests shutdown. If the fault is gone by the next sample, `shdn_req` stays high for exactly `hiccup_len`+1 cycles. If the fault is still present when the interval ends, the interval restarts.
- R8: A nonzero action with any other retry code latches the shutdown until `clear_faults`, even after the fault has gone.
- R9: After an overtemperature shutdown, restart requires a sample with `temp <= ot_flt_lim - 10`.
- R10: A sample with `vin >= vin_ov_lim` requests shutdown and sets status bit 13. The next sample below the limit releases the shutdown.
- R11: Status bit 1 reports an inconsistent setup. That covers `vin_on_lim <= vin_off_lim`, `pg_on_lim <= pg_off_lim`, any fault limit below its warning limit, and any nonzero delay field [2:0].
- R12: Status bit 6 is set whenever `shdn_req` has been high.
- R13: Sample inputs have no effect while `smp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample set valid strobe |
| vin | input | 16 | Input voltage sample |
| vout | input | 16 | Output voltage sample |
| iout | input | 16 | Output current sample |
| temp | input | 16 | Temperature sample |
| vin_on_lim | input | 16 | Lockout release level |
| vin_off_lim | input | 16 | Lockout engage level |
| vin_ov_lim | input | 16 | Input overvoltage fault limit |
| vout_ov_flt_lim | input | 16 | Output overvoltage fault limit |
| vout_ov_wrn_lim | input | 16 | Output overvoltage warning limit |
| iout_oc_flt_lim | input | 16 | Overcurrent fault limit |
| iout_oc_wrn_lim | input | 16 | Overcurrent warning limit |
| ot_flt_lim | input | 16 | Overtemperature fault limit |
| ot_wrn_lim | input | 16 | Overtemperature warning limit |
| pg_on_lim | input | 16 | Power-good assert level |
| pg_off_lim | input | 16 | Power-good negate level |
| resp_ov | input | 8 | Overvoltage response byte |
| resp_oc | input | 8 | Overcurrent response byte |
| resp_ot | input | 8 | Overtemperature response byte |
| hiccup_len | input | 12 | Hiccup interval in cycles |
| clear_faults | input | 1 | Clear-faults pulse |
| status | output | 16 | Latched status word |
| shdn_req | output | 1 | Shutdown request |
| alert_req | output | 1 | Alert request |
| pg | output | 1 | Power-good |

## Verification
On every cycle the assertions check the following:
- Status bits never drop without a clear, and the alert falls only on a clear.
- A latched-off channel stays off until a clear.
- A hiccup never ends early, and a hiccup never ends unless its recovery condition holds.
- The hysteretic flags hold between strobes, and a shutdown always shows up in the status word.

The bench scenarios cover the behaviour that needs a chosen stimulus:
- The sweeps across the lockout and power-good windows, checked against an arithmetic model.
- The exact hiccup duration.
- The 10-degree temperature recovery margin.
- Alert suppression for bits that persist through a clear.
- The effect of each response code.

// File: rtl/fm_pkg.sv
// Shared constants and types of the fault monitor.
// Assumes a 16-bit status word and three protected channels.
package fm_pkg;
    localparam int NCH = 3;
    localparam int CH_OV = 0;
    localparam int CH_OC = 1;
    localparam int CH_OT = 2;
    localparam int SW = 16;

    // Status word bit positions (the field layout is decoded by software).
    localparam int ST_VOUT_ANY = 15;
    localparam int ST_IOUT_ANY = 14;
    localparam int ST_VIN_ANY  = 13;
    localparam int ST_PG_LOST  = 11;
    localparam int ST_OFF      = 6;
    localparam int ST_VOUT_FLT = 5;
    localparam int ST_IOUT_FLT = 4;
    localparam int ST_VIN_UV   = 3;
    localparam int ST_TEMP_ANY = 2;
    localparam int ST_CFG      = 1;

    localparam logic [2:0] RETRY_ENDLESS = 3'b111;

    typedef enum logic [1:0] {
        RT_RUN  = 2'd0,
        RT_WAIT = 2'd1,
        RT_HOLD = 2'd2
    } rt_state_e;
endpackage

// File: rtl/fm_hyst.sv
// Hysteretic level flag. Sets when a strobed value reaches on_lim and clears
// when it falls below off_lim; OFF_INCL selects whether reaching off_lim
// itself also clears. Clearing wins if both hold (a misconfigured window).
module fm_hyst #(
    parameter int DW = 16,
    parameter bit OFF_INCL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] on_lim,
    input  logic [DW-1:0] off_lim,
    output logic          q
);
    logic below;

    // Select the release comparison.
    generate
        if (OFF_INCL) begin : g_incl
            assign below = (val <= off_lim);
        end else begin : g_excl
            assign below = (val < off_lim);
        end
    endgenerate

    // Update the flag only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (upd) begin
            if (below) begin
                q <= 1'b0;
            end else if (val >= on_lim) begin
                q <= 1'b1;
            end
        end
    end

    assert_hold_between_strobes_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));
endmodule

// File: rtl/fm_retry.sv
// Per-channel shutdown and restart controller driven by a response byte.
// Assumes trip and rec_ok are registered flags that update only on samples.
module fm_retry
    import fm_pkg::*;
#(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip,
    input  logic          rec_ok,
    input  logic [7:0]    resp,
    input  logic [HW-1:0] hiccup_len,
    input  logic          clear,
    output logic          down
);
    rt_state_e     st;
    logic [HW-1:0] cnt;
    logic          act_on;
    logic          endless;

    assign act_on  = (resp[7:6] != 2'b00);
    assign endless = (resp[5:3] == RETRY_ENDLESS);

    // Channel state machine: run, hiccup wait, or latched off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RT_RUN;
            cnt <= '0;
        end else begin
            case (st)
                RT_RUN: begin
                    if (trip && act_on) begin
                        if (endless) begin
                            st  <= RT_WAIT;
                            cnt <= hiccup_len;
                        end else begin
                            st <= RT_HOLD;
                        end
                    end
                end
                RT_WAIT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (rec_ok) begin
                        st <= RT_RUN;
                    end else begin
                        cnt <= hiccup_len;
                    end
                end
                RT_HOLD: begin
                    if (clear) begin
                        st <= RT_RUN;
                    end
                end
                default: st <= RT_RUN;
            endcase
        end
    end

    assign down = (st != RT_RUN);

    assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RT_HOLD && !clear) |=> (st == RT_HOLD));
    assert_hiccup_not_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RT_WAIT && cnt != '0) |=> (st == RT_WAIT));
    assert_restart_needs_recovery_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RT_WAIT) ##1 (st == RT_RUN) |-> $past(rec_ok));
    assert_ignore_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RT_RUN && !act_on) |=> (st == RT_RUN));
endmodule

// File: rtl/fm_status.sv
// Sticky status word with alert generation. A bit sets when its raw
// condition is seen; a clear reloads the word from the raw conditions.
// The alert rises on any 0-to-1 bit change and falls only on a clear.
module fm_status #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] raw,
    input  logic          clear,
    output logic [SW-1:0] stat,
    output logic          alert
);
    // Latch status bits and track new arrivals for the alert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat  <= '0;
            alert <= 1'b0;
        end else if (clear) begin
            stat  <= raw;
            alert <= 1'b0;
        end else begin
            stat  <= stat | raw;
            alert <= alert | (|(raw & ~stat));
        end
    end

    assert_bits_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((stat & $past(stat)) == $past(stat)));
    assert_alert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert) |-> $past(clear));
endmodule

// File: rtl/fault_monitor.sv
// Power-stage fault monitor. Registers limit comparisons on each sample
// strobe, runs the lockout and power-good hysteresis, steps one response
// controller per protected channel and keeps the sticky status word.
// Assumes all samples and limits share units and are unsigned.
module fault_monitor
    import fm_pkg::*;
#(
    parameter int DW = 16,
    parameter int HW = 12,
    parameter int OT_HYST = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] vin,
    input  logic [DW-1:0] vout,
    input  logic [DW-1:0] iout,
    input  logic [DW-1:0] temp,
    input  logic [DW-1:0] vin_on_lim,
    input  logic [DW-1:0] vin_off_lim,
    input  logic [DW-1:0] vin_ov_lim,
    input  logic [DW-1:0] vout_ov_flt_lim,
    input  logic [DW-1:0] vout_ov_wrn_lim,
    input  logic [DW-1:0] iout_oc_flt_lim,
    input  logic [DW-1:0] iout_oc_wrn_lim,
    input  logic [DW-1:0] ot_flt_lim,
    input  logic [DW-1:0] ot_wrn_lim,
    input  logic [DW-1:0] pg_on_lim,
    input  logic [DW-1:0] pg_off_lim,
    input  logic [7:0]    resp_ov,
    input  logic [7:0]    resp_oc,
    input  logic [7:0]    resp_ot,
    input  logic [HW-1:0] hiccup_len,
    input  logic          clear_faults,
    output logic [SW-1:0] status,
    output logic          shdn_req,
    output logic          alert_req,
    output logic          pg
);
    localparam logic [DW:0] HYST_X = (DW+1)'(OT_HYST);

    logic ov_f, ov_w, oc_f, oc_w, ot_f, ot_w, ot_rec, vinov_f;
    logic uv_ok;
    logic cfg_err;
    logic [NCH-1:0] trip_v;
    logic [NCH-1:0] rec_v;
    logic [NCH-1:0] down_v;
    logic [7:0]     resp_a [NCH];
    logic [SW-1:0]  raw;

    // Capture limit comparisons on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_f    <= 1'b0;
            ov_w    <= 1'b0;
            oc_f    <= 1'b0;
            oc_w    <= 1'b0;
            ot_f    <= 1'b0;
            ot_w    <= 1'b0;
            ot_rec  <= 1'b1;
            vinov_f <= 1'b0;
        end else if (smp_valid) begin
            ov_f    <= (vout >= vout_ov_flt_lim);
            ov_w    <= (vout >= vout_ov_wrn_lim);
            oc_f    <= (iout >= iout_oc_flt_lim);
            oc_w    <= (iout >= iout_oc_wrn_lim);
            ot_f    <= (temp >= ot_flt_lim);
            ot_w    <= (temp >= ot_wrn_lim);
            ot_rec  <= (({1'b0, temp} + HYST_X) <= {1'b0, ot_flt_lim});
            vinov_f <= (vin >= vin_ov_lim);
        end
    end

    fm_hyst #(.DW(DW), .OFF_INCL(1'b0)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .upd(smp_valid), .val(vin),
        .on_lim(vin_on_lim), .off_lim(vin_off_lim), .q(uv_ok)
    );

    fm_hyst #(.DW(DW), .OFF_INCL(1'b1)) u_pgood (
        .clk(clk), .rst_n(rst_n), .upd(smp_valid), .val(vout),
        .on_lim(pg_on_lim), .off_lim(pg_off_lim), .q(pg)
    );

    // Gather per-channel trip, recovery and response inputs.
    always_comb begin
        trip_v[CH_OV] = ov_f;
        trip_v[CH_OC] = oc_f;
        trip_v[CH_OT] = ot_f;
        rec_v[CH_OV]  = !ov_f;
        rec_v[CH_OC]  = !oc_f;
        rec_v[CH_OT]  = ot_rec;
        resp_a[CH_OV] = resp_ov;
        resp_a[CH_OC] = resp_oc;
        resp_a[CH_OT] = resp_ot;
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            fm_retry #(.HW(HW)) u_retry (
                .clk(clk), .rst_n(rst_n), .trip(trip_v[i]), .rec_ok(rec_v[i]),
                .resp(resp_a[i]), .hiccup_len(hiccup_len),
                .clear(clear_faults), .down(down_v[i])
            );
        end
    endgenerate

    assign shdn_req = (|down_v) | !uv_ok | vinov_f;

    // Flag an inconsistent limit or response setup.
    always_comb begin
        cfg_err = (vin_on_lim <= vin_off_lim) || (pg_on_lim <= pg_off_lim)
               || (vout_ov_flt_lim < vout_ov_wrn_lim)
               || (iout_oc_flt_lim < iout_oc_wrn_lim)
               || (ot_flt_lim < ot_wrn_lim)
               || (resp_ov[2:0] != 3'b000) || (resp_oc[2:0] != 3'b000)
               || (resp_ot[2:0] != 3'b000);
    end

    // Assemble the live status conditions.
    always_comb begin
        raw              = '0;
        raw[ST_VOUT_ANY] = ov_f | ov_w;
        raw[ST_IOUT_ANY] = oc_f | oc_w;
        raw[ST_VIN_ANY]  = vinov_f | !uv_ok;
        raw[ST_PG_LOST]  = !pg;
        raw[ST_OFF]      = shdn_req;
        raw[ST_VOUT_FLT] = ov_f;
        raw[ST_IOUT_FLT] = oc_f;
        raw[ST_VIN_UV]   = !uv_ok;
        raw[ST_TEMP_ANY] = ot_f | ot_w;
        raw[ST_CFG]      = cfg_err;
    end

    fm_status #(.SW(SW)) u_status (
        .clk(clk), .rst_n(rst_n), .raw(raw), .clear(clear_faults),
        .stat(status), .alert(alert_req)
    );

    assert_off_reported_R12: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> status[ST_OFF]);
endmodule

// File: tb/fault_monitor_bench.sv
module fault_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [15:0] vin = 16'd48, vout = 16'd12, iout = 16'd10, temp = 16'd50;
    logic [15:0] vin_on_lim = 16'd34, vin_off_lim = 16'd32, vin_ov_lim = 16'd110;
    logic [15:0] vout_ov_flt_lim = 16'd15, vout_ov_wrn_lim = 16'd15;
    logic [15:0] iout_oc_flt_lim = 16'd50, iout_oc_wrn_lim = 16'd46;
    logic [15:0] ot_flt_lim = 16'd120, ot_wrn_lim = 16'd115;
    logic [15:0] pg_on_lim = 16'd11, pg_off_lim = 16'd9;
    logic [7:0]  resp_ov = 8'hB8, resp_oc = 8'hB8, resp_ot = 8'hB8;
    logic [11:0] hiccup_len = 12'd20;
    logic clear_faults = 1'b0;
    logic [15:0] status;
    logic shdn_req, alert_req, pg;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_monitor u_fault_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .vin(vin), .vout(vout), .iout(iout), .temp(temp),
        .vin_on_lim(vin_on_lim), .vin_off_lim(vin_off_lim), .vin_ov_lim(vin_ov_lim),
        .vout_ov_flt_lim(vout_ov_flt_lim), .vout_ov_wrn_lim(vout_ov_wrn_lim),
        .iout_oc_flt_lim(iout_oc_flt_lim), .iout_oc_wrn_lim(iout_oc_wrn_lim),
        .ot_flt_lim(ot_flt_lim), .ot_wrn_lim(ot_wrn_lim),
        .pg_on_lim(pg_on_lim), .pg_off_lim(pg_off_lim),
        .resp_ov(resp_ov), .resp_oc(resp_oc), .resp_ot(resp_ot),
        .hiccup_len(hiccup_len), .clear_faults(clear_faults),
        .status(status), .shdn_req(shdn_req), .alert_req(alert_req), .pg(pg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(input int a, input int b, input int c, input int d);
        vin = 16'(a); vout = 16'(b); iout = 16'(c); temp = 16'(d);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clr();
        clear_faults = 1'b1;
        @(negedge clk);
        clear_faults = 1'b0;
        cyc(1);
    endtask

    task automatic benign();
        smp(48, 12, 10, 50);
        cyc(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit ok;
        bit pgm;
        int n;
        cyc(3);
        // R1 R2 R4: reset state
        check("R4 reset status", status, 16'h0000);
        check("R5 reset alert", alert_req, 0);
        check("R1 reset lockout", shdn_req, 1);
        check("R2 reset pg", pg, 0);
        rst_n = 1'b1;
        cyc(2);
        benign();
        clr();
        check("R4 clean after clear", status, 16'h0000);
        check("R5 alert cleared", alert_req, 0);
        check("R1 released", shdn_req, 0);
        check("R2 pg up", pg, 1);

        // R1: lockout hysteresis sweep down then up
        ok = 1'b1;
        for (int v = 40; v >= 20; v--) begin
            smp(v, 12, 10, 50); cyc(2);
            if (v >= 34) ok = 1'b1;
            if (v < 32) ok = 1'b0;
            check("R1 sweep down", shdn_req, !ok);
        end
        check("R1 lockout status bits", status & 16'h2008, 16'h2008);
        for (int v = 20; v <= 40; v++) begin
            smp(v, 12, 10, 50); cyc(2);
            if (v >= 34) ok = 1'b1;
            if (v < 32) ok = 1'b0;
            check("R1 sweep up", shdn_req, !ok);
        end
        benign(); clr();

        // R2: power-good window sweep
        vout_ov_flt_lim = 16'd20; vout_ov_wrn_lim = 16'd20;
        pgm = 1'b1;
        for (int v = 16; v >= 0; v--) begin
            smp(48, v, 10, 50); cyc(2);
            if (v <= 9) pgm = 1'b0; else if (v >= 11) pgm = 1'b1;
            check("R2 sweep down", pg, pgm);
        end
        for (int v = 0; v <= 16; v++) begin
            smp(48, v, 10, 50); cyc(2);
            if (v <= 9) pgm = 1'b0; else if (v >= 11) pgm = 1'b1;
            check("R2 sweep up", pg, pgm);
        end
        vout_ov_flt_lim = 16'd15; vout_ov_wrn_lim = 16'd15;
        benign(); clr();
        check("R4 reload clean", status, 16'h0000);

        // R13: no strobe, no effect
        vout = 16'd16; iout = 16'd60; vin = 16'd10;
        cyc(6);
        check("R13 ignored shdn", shdn_req, 0);
        check("R13 ignored status", status, 16'h0000);
        check("R13 ignored pg", pg, 1);
        benign();

        // R7: exact hiccup length with a fault gone by the next sample
        smp(48, 16, 10, 50);
        smp(48, 12, 10, 50);
        n = 0;
        while (shdn_req && n < 1000) begin n++; @(negedge clk); end
        check("R7 hiccup cycles", n, 21);
        check("R3 R12 ov status latched", status, 16'h8060);
        check("R5 alert on fault", alert_req, 1);
        clr();
        // R7: persistent fault keeps retrying
        smp(48, 16, 10, 50); cyc(70);
        check("R7 persistent shutdown", shdn_req, 1);
        smp(48, 12, 10, 50); cyc(26);
        check("R7 recovered", shdn_req, 0);
        clr();

        // R6: action 00 only records
        resp_ov = 8'h00;
        smp(48, 16, 10, 50); cyc(3);
        check("R6 no shutdown", shdn_req, 0);
        check("R6 R3 recorded", status, 16'h8020);
        resp_ov = 8'hB8;
        benign(); clr();

        // R8: latch-off on overcurrent
        resp_oc = 8'hC0;
        smp(48, 12, 55, 50); cyc(3);
        check("R8 shutdown", shdn_req, 1);
        check("R3 oc status", status, 16'h4050);
        smp(48, 12, 10, 50); cyc(100);
        check("R8 still latched", shdn_req, 1);
        clr();
        check("R8 released by clear", shdn_req, 0);
        clr();
        check("R4 clean", status, 16'h0000);
        resp_oc = 8'hB8;

        // R3: overcurrent warning only
        smp(48, 12, 47, 50); cyc(3);
        check("R3 oc warning", status, 16'h4000);
        check("R3 oc warn no shdn", shdn_req, 0);
        benign(); clr();

        // R9: temperature recovery margin
        smp(48, 12, 10, 125); cyc(3);
        check("R9 ot shutdown", shdn_req, 1);
        check("R3 ot status", status, 16'h0044);
        smp(48, 12, 10, 115); cyc(60);
        check("R9 hold at 115", shdn_req, 1);
        smp(48, 12, 10, 111); cyc(60);
        check("R9 hold at 111", shdn_req, 1);
        smp(48, 12, 10, 110); cyc(30);
        check("R9 restart at 110", shdn_req, 0);
        clr();

        // R5: alert rises on a new bit, not on a persisting one
        smp(48, 12, 10, 117); cyc(3);
        check("R3 temp warning", status, 16'h0004);
        check("R5 alert new bit", alert_req, 1);
        clr();
        check("R5 persist status", status, 16'h0004);
        check("R5 no re-alert", alert_req, 0);
        vout_ov_wrn_lim = 16'd14;
        smp(48, 14, 10, 117); cyc(3);
        check("R3 ov warning", status, 16'h8004);
        check("R5 alert second bit", alert_req, 1);
        vout_ov_wrn_lim = 16'd15;
        benign(); clr();

        // R10: input overvoltage
        smp(115, 12, 10, 50); cyc(3);
        check("R10 shutdown", shdn_req, 1);
        check("R10 status", status, 16'h2040);
        smp(48, 12, 10, 50); cyc(3);
        check("R10 release", shdn_req, 0);
        check("R10 latched", status, 16'h2040);
        clr();
        check("R4 clean", status, 16'h0000);

        // R11: setup inconsistencies
        pg_on_lim = 16'd8; cyc(3);
        check("R11 pg window", status, 16'h0002);
        pg_on_lim = 16'd11; clr();
        resp_oc = 8'hB9; cyc(3);
        check("R11 delay code", status, 16'h0002);
        resp_oc = 8'hB8; clr();
        iout_oc_wrn_lim = 16'd51; cyc(3);
        check("R11 warn above fault", status, 16'h0002);
        iout_oc_wrn_lim = 16'd46; clr();
        check("R11 clean", status, 16'h0000);

        finish_run();
    end
endmodule